// File: doc/BRIEF.md
# Loadable Saturating Countdown Timer

This block is a small clocked down-counter. A parallel value is written into its state register with a load strobe. While the count enable is held high, the register steps down by one on every rising clock edge until it reaches zero. It then stays at zero until software or a neighbouring block loads a fresh value.

The current count is presented directly from the state flip-flops. A terminal flag tells the surrounding logic that the countdown has finished. The flag is only raised while the enable is held, so dropping the enable clears it in the same cycle.

Top module: `cdown_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` becomes 0 after that edge. This applies whatever the load and enable inputs are.
- R2: When `ld_strobe` is high at a rising edge outside reset, `count` takes the value of `ld_value` after that edge.
- R3: When `ld_strobe` and `cnt_en` are both high at the same edge, the loaded value wins and no decrement is applied.
- R4: When `cnt_en` is high, `ld_strobe` is low and `count` is nonzero at an edge, `count` becomes `count - 1`.
- R5: When `count` is 0, `cnt_en` is high and `ld_strobe` is low, `count` stays 0. It never wraps to all ones (7 for the default width).
- R6: When `cnt_en` and `ld_strobe` are both low, `count` keeps its value across the edge.
- R7: `at_zero` is 1 exactly when `count` is 0 and `cnt_en` is 1. It is combinational, so it follows `cnt_en` within the same cycle.
- R8: Loading the value 0 sends the timer straight to the terminal state. `at_zero` is then high in the next cycle if `cnt_en` is high.
- R9: The count width is the parameter `W`, 3 by default. The count holds values from 0 up to 2^W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_strobe | input | 1 | Load the parallel value on this edge |
| ld_value | input | W | Parallel value to load |
| cnt_en | input | 1 | Count enable |
| count | output | W | Current state of the counter |
| at_zero | output | 1 | Terminal flag: count is zero and enable is high |

## Verification
On every cycle, the checker verifies the following: the result of a load, the priority of load over counting, the single-step decrement, saturation at zero, holding while idle, and the relation between the terminal flag, the count and the enable.

Some behaviour can only be shown by the bench's scenarios. One example is a full countdown from the maximum value through saturation. Another is a zero loaded while enabled that raises the flag one cycle later. A third is the flag being dropped and raised again as the enable toggles while the count sits at zero. The random stimulus mixes these operations against a reference model kept in the bench.

// File: rtl/cdown_timer_pkg.sv
// Package: shared operation encoding for the countdown timer.
// Assumes: one operation is chosen per clock edge.
package cdown_timer_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_KEEP  = 2'd3
    } tmr_op_e;

endpackage

// File: rtl/cdown_timer_ctrl.sv
// Module: picks the single operation applied at the next clock edge.
// Priority, highest first: reset, load, decrement, hold.
// Assumes: is_zero reflects the current state register.
module cdown_timer_ctrl
    import cdown_timer_pkg::*;
(
    input  logic    rst_n,
    input  logic    ld_strobe,
    input  logic    cnt_en,
    input  logic    is_zero,
    output tmr_op_e op
);

    // Priority selection of the operation for this cycle.
    always_comb begin
        if (!rst_n) begin
            op = OP_CLEAR;
        end else if (ld_strobe) begin
            op = OP_LOAD;
        end else if (cnt_en && !is_zero) begin
            op = OP_STEP;
        end else begin
            op = OP_KEEP;
        end
    end

endmodule

// File: rtl/cdown_timer_next.sv
// Module: next-state datapath. It builds a ripple-borrow decrementer and
// selects the next value for the chosen operation.
// Assumes: OP_STEP is never issued when the state is zero.
module cdown_timer_next
    import cdown_timer_pkg::*;
#(
    parameter int W = 3
) (
    input  tmr_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ld_value,
    output logic [W-1:0] nxt
);

    logic [W:0]   borrow;
    logic [W-1:0] dec;

    assign borrow[0] = 1'b1;

    // One borrow stage per bit of the state.
    for (genvar i = 0; i < W; i++) begin : g_borrow
        assign dec[i]      = cur[i] ^ borrow[i];
        assign borrow[i+1] = borrow[i] & ~cur[i];
    end

    // Next-value multiplexer driven by the operation code.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ld_value;
            OP_STEP:  nxt = dec;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cdown_timer_state.sv
// Module: bank of edge-triggered D flip-flops holding the count.
// Assumes: clearing is already folded into d by the next-state logic.
module cdown_timer_state #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One D flip-flop per state bit.
    for (genvar i = 0; i < W; i++) begin : g_dff
        always_ff @(posedge clk) begin
            q[i] <= d[i];
        end
    end

endmodule

// File: rtl/cdown_timer_flag.sv
// Module: zero detection and the enable-gated terminal flag.
// Assumes: the flag is combinational and may be used in the same cycle.
module cdown_timer_flag #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  logic         cnt_en,
    output logic         is_zero,
    output logic         at_zero
);

    // Reduction NOR detects the terminal state; the enable gates the flag.
    always_comb begin
        is_zero = ~|cur;
        at_zero = is_zero & cnt_en;
    end

endmodule

// File: rtl/cdown_timer.sv
// Module: top level of the loadable countdown timer that saturates at zero.
// Assumes: all inputs are synchronous to clk; rst_n is a synchronous,
// active-low reset.
module cdown_timer
    import cdown_timer_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_strobe,
    input  logic [W-1:0] ld_value,
    input  logic         cnt_en,
    output logic [W-1:0] count,
    output logic         at_zero
);

    tmr_op_e      op;
    logic         is_zero;
    logic [W-1:0] nxt;

    cdown_timer_ctrl u_ctrl (
        .rst_n     (rst_n),
        .ld_strobe (ld_strobe),
        .cnt_en    (cnt_en),
        .is_zero   (is_zero),
        .op        (op)
    );

    cdown_timer_next #(.W(W)) u_next (
        .op       (op),
        .cur      (count),
        .ld_value (ld_value),
        .nxt      (nxt)
    );

    cdown_timer_state #(.W(W)) u_state (
        .clk (clk),
        .d   (nxt),
        .q   (count)
    );

    cdown_timer_flag #(.W(W)) u_flag (
        .cur     (count),
        .cnt_en  (cnt_en),
        .is_zero (is_zero),
        .at_zero (at_zero)
    );

endmodule

// File: rtl/cdown_timer_chk.sv
// Module: protocol checker for cdown_timer, attached through bind.
// Assumes: observes the top-level ports only.
module cdown_timer_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_strobe,
    input logic [W-1:0] ld_value,
    input logic         cnt_en,
    input logic [W-1:0] count,
    input logic         at_zero
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> count == '0); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |=> count == $past(ld_value)); // R2
    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && cnt_en) |=> count == $past(ld_value)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_strobe && cnt_en && count != '0) |=> count == $past(count) - 1'b1); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_strobe && cnt_en && count == '0) |=> count == '0); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_strobe && !cnt_en) |=> $stable(count)); // R6
    AST_FLAG_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |-> (count == '0 && cnt_en)); // R7
    AST_FLAG_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && cnt_en) |-> at_zero); // R7
    AST_ZERO_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && ld_value == '0) |=> (cnt_en |-> at_zero)); // R8

endmodule

bind cdown_timer cdown_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_strobe (ld_strobe),
    .ld_value  (ld_value),
    .cnt_en    (cnt_en),
    .count     (count),
    .at_zero   (at_zero)
);

// File: tb/cdown_timer_tb.sv
module cdown_timer_tb;

    localparam int W   = 3;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_strobe = 1'b0;
    logic [W-1:0] ld_value = '0;
    logic         cnt_en = 1'b0;
    logic [W-1:0] count;
    logic         at_zero;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;

    cdown_timer #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_strobe (ld_strobe),
        .ld_value  (ld_value),
        .cnt_en    (cnt_en),
        .count     (count),
        .at_zero   (at_zero)
    );

    function automatic logic [W-1:0] exp_next(input logic [W-1:0] cur, input logic rn,
                                              input logic ld, input logic [W-1:0] v,
                                              input logic en);
        if (!rn)            return '0;
        if (ld)             return v;
        if (en && cur != 0) return cur - 1'b1;
        return cur;
    endfunction

    function automatic logic exp_flag(input logic [W-1:0] cur, input logic en);
        return (cur == 0) && en;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Apply one cycle of inputs, check the flag before the edge and the count after it.
    task automatic cycle(input logic rn, input logic ld, input logic [W-1:0] v,
                         input logic en, input string req);
        rst_n = rn; ld_strobe = ld; ld_value = v; cnt_en = en;
        #1;
        if (rn) check("R7 flag", int'(at_zero), int'(exp_flag(model, en)));
        model = exp_next(model, rn, ld, v, en);
        @(posedge clk);
        #1;
        check(req, int'(count), int'(model));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cycle(1'b0, 1'b1, 3'd5, 1'b1, "R1 reset");
        cycle(1'b0, 1'b0, 3'd0, 1'b0, "R1 reset");
        // R2 load the top value, then R4 count it down; R5 saturates at zero.
        cycle(1'b1, 1'b1, 3'(MAX), 1'b0, "R2 load");
        for (int i = 0; i < MAX; i++) cycle(1'b1, 1'b0, 3'd0, 1'b1, "R4 step");
        cycle(1'b1, 1'b0, 3'd0, 1'b1, "R5 no wrap");
        cycle(1'b1, 1'b0, 3'd0, 1'b1, "R5 no wrap");
        check("R7 flag at zero", int'(at_zero), 1);
        // R7 the flag drops with the enable in the same cycle.
        cnt_en = 1'b0; #1;
        check("R7 flag drop", int'(at_zero), 0);
        // R6 hold with the enable low.
        cycle(1'b1, 1'b1, 3'd4, 1'b0, "R2 load");
        cycle(1'b1, 1'b0, 3'd0, 1'b0, "R6 hold");
        cycle(1'b1, 1'b0, 3'd0, 1'b0, "R6 hold");
        // R3 load wins over the enable.
        cycle(1'b1, 1'b1, 3'd6, 1'b1, "R3 load priority");
        // R8 a zero load raises the flag in the next cycle.
        cycle(1'b1, 1'b1, 3'd0, 1'b1, "R8 zero load");
        check("R8 flag", int'(at_zero), 1);
        // R9 every value the width allows can be loaded.
        for (int v = 0; v <= MAX; v++) cycle(1'b1, 1'b1, 3'(v), 1'b0, "R9 range");
        // Random mix of all operations.
        for (int i = 0; i < 3000; i++) begin
            logic rn, ld, en;
            logic [W-1:0] v;
            rn = ($urandom % 40) != 0;
            ld = ($urandom % 6) == 0;
            en = ($urandom % 4) != 0;
            v  = 3'($urandom);
            cycle(rn, ld, v, en, "R4 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule